// File: doc/BRIEF.md
# Programmable LCD Timing Generator

This block produces the raster timing for a parallel RGB panel. It emits horizontal and vertical sync, a data-enable strobe and zero-based pixel coordinates, all advancing on the dot clock. Every interval is a run-time input:

- sync width
- back porch
- active size
- front porch

The horizontal intervals count dots and the vertical intervals count lines. The two sync outputs and the forwarded dot clock each have their own polarity select.

The timing inputs are captured into shadow copies only at the first dot of a frame, so a frame in progress keeps its geometry. At that same dot the block raises a one-cycle frame interrupt. The same dot is also the only point where the front/back framebuffer select may flip. A pulse on the swap request input arms a pending flag. The flag is consumed, and the select toggles, at the next frame start. Software then refills the buffer that has just gone idle.

Top module: `lcd_timing_gen`

## Requirements
- R1: Within a line, counting dots from 0 at line start, the horizontal sync is active for dots [0, HSW). The active window is dots [HSW+HBP, HSW+HBP+HACT). The line lasts HSW+HBP+HACT+HFP dots, after which the dot count returns to 0.
- R2: Within a frame, counting lines from 0, the vertical sync is active for lines [0, VSW). Active lines are [VSW+VBP, VSW+VBP+VACT). The frame lasts VSW+VBP+VACT+VFP lines.
- R3: `de` is 1 only when both the dot and the line fall in their active windows. Inside the window, `px_x` and `px_y` give the zero-based position. Outside it, `de`, `px_x` and `px_y` are all 0.
- R4: `hsync` equals `pol_hs` while horizontal sync is active and `!pol_hs` otherwise. `vsync` follows `pol_vs` in the same way. Both polarity inputs act on the very next sampled value.
- R5: `dclk_out` equals `clk` when `pol_dclk` is 0 and `~clk` when it is 1.
- R6: At the first dot of a frame, vertical sync and horizontal sync both become active in the same cycle.
- R7: Vertical sync width is counted in whole lines. VSW=1 keeps `vsync` active for exactly one full line of dots.
- R8: `frame_irq` is 1 for exactly one dot, the first dot of each frame (dot 0 of line 0).
- R9: A one-cycle `swap_req` sets `swap_pending` at the next edge. At the next frame start edge, a pending swap toggles `buf_sel` and clears `swap_pending` together. The new `buf_sel` is visible in the `frame_irq` cycle. Without a pending swap, `buf_sel` never changes.
- R10: Timing inputs are captured only at frame start. A change in mid-frame has no effect until the following frame.
- R11: While `rst_n` is low, both syncs sit at their inactive levels and `de`, `frame_irq`, `buf_sel` and `swap_pending` are 0. The first frame begins at the first rising edge of `clk` with `rst_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pol_hs | input | 1 | Horizontal sync active level |
| pol_vs | input | 1 | Vertical sync active level |
| pol_dclk | input | 1 | Invert forwarded dot clock when 1 |
| cfg_hsw | input | FW | Horizontal sync width, dots |
| cfg_hbp | input | FW | Horizontal back porch, dots |
| cfg_hact | input | FW | Active dots per line |
| cfg_hfp | input | FW | Horizontal front porch, dots |
| cfg_vsw | input | FW | Vertical sync width, lines |
| cfg_vbp | input | FW | Vertical back porch, lines |
| cfg_vact | input | FW | Active lines per frame |
| cfg_vfp | input | FW | Vertical front porch, lines |
| swap_req | input | 1 | One-cycle request to swap buffers at next frame start |
| dclk_out | output | 1 | Forwarded dot clock |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| px_x | output | FW | Active-area column |
| px_y | output | FW | Active-area row |
| frame_irq | output | 1 | One-dot pulse at frame start |
| buf_sel | output | 1 | Active framebuffer select |
| swap_pending | output | 1 | Swap armed, waiting for frame start |

## Verification
The assertions assume that every timing field is at least 1 whenever it is captured at frame start. With that, a line is at least four dots and a frame at least four lines. The assertions also assume that the sum of four fields fits the internal counters. The stimulus uses only two small geometries with all fields between 1 and 5. It switches geometry and polarity while a frame is running, so that the capture point is exercised. It places swap requests well away from the frame boundaries, so the set and clear of the pending flag never share an edge.

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen #(
  parameter int FW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pol_hs,
  input  logic          pol_vs,
  input  logic          pol_dclk,
  input  logic [FW-1:0] cfg_hsw,
  input  logic [FW-1:0] cfg_hbp,
  input  logic [FW-1:0] cfg_hact,
  input  logic [FW-1:0] cfg_hfp,
  input  logic [FW-1:0] cfg_vsw,
  input  logic [FW-1:0] cfg_vbp,
  input  logic [FW-1:0] cfg_vact,
  input  logic [FW-1:0] cfg_vfp,
  input  logic          swap_req,
  output logic          dclk_out,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [FW-1:0] px_x,
  output logic [FW-1:0] px_y,
  output logic          frame_irq,
  output logic          buf_sel,
  output logic          swap_pending
);

  localparam int CW = FW + 2;

  logic          run;
  logic [CW-1:0] hcnt, vcnt;
  logic [FW-1:0] s_hsw, s_hbp, s_hact, s_hfp;
  logic [FW-1:0] s_vsw, s_vbp, s_vact, s_vfp;

  logic [CW-1:0] htot, vtot, hstart, vstart, hend, vend;
  logic          eol, eof, load;
  logic          hs_act, vs_act, h_in, v_in;
  logic [CW-1:0] xoff, yoff;

  assign htot   = CW'(s_hsw) + CW'(s_hbp) + CW'(s_hact) + CW'(s_hfp);
  assign vtot   = CW'(s_vsw) + CW'(s_vbp) + CW'(s_vact) + CW'(s_vfp);
  assign hstart = CW'(s_hsw) + CW'(s_hbp);
  assign vstart = CW'(s_vsw) + CW'(s_vbp);
  assign hend   = hstart + CW'(s_hact);
  assign vend   = vstart + CW'(s_vact);

  assign eol  = (hcnt == htot - CW'(1));
  assign eof  = eol && (vcnt == vtot - CW'(1));
  assign load = !run || eof;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run    <= 1'b0;
      hcnt   <= '0;
      vcnt   <= '0;
      s_hsw  <= '0;
      s_hbp  <= '0;
      s_hact <= '0;
      s_hfp  <= '0;
      s_vsw  <= '0;
      s_vbp  <= '0;
      s_vact <= '0;
      s_vfp  <= '0;
    end else begin
      run <= 1'b1;
      if (load) begin
        hcnt   <= '0;
        vcnt   <= '0;
        s_hsw  <= cfg_hsw;
        s_hbp  <= cfg_hbp;
        s_hact <= cfg_hact;
        s_hfp  <= cfg_hfp;
        s_vsw  <= cfg_vsw;
        s_vbp  <= cfg_vbp;
        s_vact <= cfg_vact;
        s_vfp  <= cfg_vfp;
      end else if (eol) begin
        hcnt <= '0;
        vcnt <= vcnt + CW'(1);
      end else begin
        hcnt <= hcnt + CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_sel      <= 1'b0;
      swap_pending <= 1'b0;
    end else begin
      if (load && swap_pending) buf_sel <= ~buf_sel;
      if (swap_req)  swap_pending <= 1'b1;
      else if (load) swap_pending <= 1'b0;
    end
  end

  assign hs_act = run && (hcnt < CW'(s_hsw));
  assign vs_act = run && (vcnt < CW'(s_vsw));
  assign h_in   = (hcnt >= hstart) && (hcnt < hend);
  assign v_in   = (vcnt >= vstart) && (vcnt < vend);
  assign de     = run && h_in && v_in;
  assign xoff   = hcnt - hstart;
  assign yoff   = vcnt - vstart;
  assign px_x   = de ? xoff[FW-1:0] : '0;
  assign px_y   = de ? yoff[FW-1:0] : '0;

  assign hsync     = hs_act ? pol_hs : ~pol_hs;
  assign vsync     = vs_act ? pol_vs : ~pol_vs;
  assign frame_irq = run && (hcnt == '0) && (vcnt == '0);
  assign dclk_out  = clk ^ pol_dclk;

  AST_DE_CLEAR_OF_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (!hs_act && !vs_act));                                        // R3
  AST_COORD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (px_x < s_hact && px_y < s_vact));                            // R3
  AST_VS_WITH_HS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vs_act) |-> $rose(hs_act));                                    // R6
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_irq |=> !frame_irq);                                           // R8
  AST_SWAP_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(buf_sel) |-> frame_irq);                                    // R9
  AST_PEND_CLEAR_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(swap_pending) |-> frame_irq);                                  // R9
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !eof) |=> ($stable(s_hact) && $stable(s_vsw) && $stable(s_hsw))); // R10

endmodule

// File: tb/lcd_timing_gen_test.sv
module lcd_timing_gen_test;
  localparam int FW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pol_hs = 1'b1, pol_vs = 1'b1, pol_dclk = 1'b0;
  logic [FW-1:0] cfg_hsw, cfg_hbp, cfg_hact, cfg_hfp;
  logic [FW-1:0] cfg_vsw, cfg_vbp, cfg_vact, cfg_vfp;
  logic swap_req = 1'b0;
  logic dclk_out, hsync, vsync, de, frame_irq, buf_sel, swap_pending;
  logic [FW-1:0] px_x, px_y;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lcd_timing_gen #(.FW(FW)) uut (
    .clk(clk), .rst_n(rst_n), .pol_hs(pol_hs), .pol_vs(pol_vs), .pol_dclk(pol_dclk),
    .cfg_hsw(cfg_hsw), .cfg_hbp(cfg_hbp), .cfg_hact(cfg_hact), .cfg_hfp(cfg_hfp),
    .cfg_vsw(cfg_vsw), .cfg_vbp(cfg_vbp), .cfg_vact(cfg_vact), .cfg_vfp(cfg_vfp),
    .swap_req(swap_req), .dclk_out(dclk_out), .hsync(hsync), .vsync(vsync), .de(de),
    .px_x(px_x), .px_y(px_y), .frame_irq(frame_irq), .buf_sel(buf_sel),
    .swap_pending(swap_pending));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic set_cfg(input int a, b, c, d, e, f, g, h);
    cfg_hsw = FW'(a); cfg_hbp = FW'(b); cfg_hact = FW'(c); cfg_hfp = FW'(d);
    cfg_vsw = FW'(e); cfg_vbp = FW'(f); cfg_vact = FW'(g); cfg_vfp = FW'(h);
  endtask

  int hsw, hbp, hact, hfp, vsw, vbp, vact, vfp;
  int h, v;
  bit mbuf, mpend, req_prev;

  initial begin
    set_cfg(2, 3, 5, 2, 1, 2, 3, 1);
    repeat (3) @(negedge clk);
    check(hsync === 1'b0, "R11 hsync", hsync, 0);
    check(vsync === 1'b0, "R11 vsync", vsync, 0);
    check(de === 1'b0, "R11 de", de, 0);
    check(frame_irq === 1'b0, "R11 irq", frame_irq, 0);
    check(buf_sel === 1'b0 && swap_pending === 1'b0, "R11 buffer", buf_sel, 0);
    rst_n = 1'b1;
    mbuf = 0; mpend = 0; req_prev = 0;
    for (int step = 0; step < 330; step++) begin
      bit ld, ehs, evs, ede, eirq;
      int ex, ey, hst, vst;
      @(negedge clk);
      ld = 0;
      if (step == 0) begin
        h = 0; v = 0; ld = 1;
      end else begin
        h++;
        if (h == hsw + hbp + hact + hfp) begin
          h = 0; v++;
          if (v == vsw + vbp + vact + vfp) begin v = 0; ld = 1; end
        end
      end
      if (ld) begin
        hsw = int'(cfg_hsw); hbp = int'(cfg_hbp); hact = int'(cfg_hact); hfp = int'(cfg_hfp);
        vsw = int'(cfg_vsw); vbp = int'(cfg_vbp); vact = int'(cfg_vact); vfp = int'(cfg_vfp);
        if (mpend) begin mbuf = ~mbuf; mpend = 0; end
      end
      if (req_prev) mpend = 1;
      req_prev = 0;

      hst = hsw + hbp; vst = vsw + vbp;
      ehs = (h < hsw);
      evs = (v < vsw);
      ede = (h >= hst) && (h < hst + hact) && (v >= vst) && (v < vst + vact);
      ex = ede ? h - hst : 0;
      ey = ede ? v - vst : 0;
      eirq = (h == 0) && (v == 0);

      check(hsync === (ehs ? pol_hs : ~pol_hs), "R1 R4 hsync", hsync, ehs ? pol_hs : ~pol_hs);
      check(vsync === (evs ? pol_vs : ~pol_vs), "R2 R7 vsync", vsync, evs ? pol_vs : ~pol_vs);
      check(de === ede, (step > 120 && step < 168) ? "R10 de" : "R3 de", de, ede);
      check(int'(px_x) == ex && int'(px_y) == ey, "R3 coords", int'(px_x) * 1000 + int'(px_y), ex * 1000 + ey);
      check(frame_irq === eirq, "R8 irq", frame_irq, eirq);
      check(buf_sel === mbuf && swap_pending === mpend, "R9 swap",
            2 * buf_sel + swap_pending, 2 * mbuf + mpend);
      check(dclk_out === pol_dclk, "R5 dclk low phase", dclk_out, pol_dclk);
      if (eirq)
        check(hsync === pol_hs && vsync === pol_vs, "R6 aligned sync", 2 * hsync + vsync, 2 * pol_hs + pol_vs);

      if (step == 30 || step == 200) begin swap_req = 1'b1; req_prev = 1; end
      else swap_req = 1'b0;
      if (step == 120) set_cfg(1, 2, 4, 3, 2, 1, 2, 2);
      if (step == 150) begin pol_hs = 1'b0; pol_vs = 1'b0; pol_dclk = 1'b1; end
    end
    @(posedge clk); #1;
    check(dclk_out === ~pol_dclk, "R5 dclk high phase", dclk_out, ~pol_dclk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule